// File: doc/BRIEF.md
# Block-Tiled Address Remapper

This block turns a linear sample offset inside a picture plane into an address in which every rectangular tile of samples sits in one contiguous range. It feeds a cache model that has to see the address pattern of a tiled memory layout. Each request carries an offset, the plane stride as a base-2 exponent, and a mode select. Linear mode returns the offset unchanged. Tiled mode splits the offset into a column and a row. It then splits both into a tile coordinate and a position inside the tile. Finally it rebuilds the address in tile-major order.

Tile width and tile height are powers of two set by parameters (32 by 16 by default). The stride is also a power of two. Every divide and modulo therefore reduces to a shift or a mask, and the datapath has no divider. The block is a two-stage pipeline. A valid bit travels with each result, and no request is ever stalled.

Top module: `tile_addr_remap`

## Requirements
- R1: With mode value 0 (linear) the result equals the input offset, bit for bit.
- R2: With mode value 1 (tiled), let S = 2^in_stride_log2, W = 2^BLK_W_LOG2 and H = 2^BLK_H_LOG2. The column x is offset mod S and the row y is offset div S. The result is S·(y div H)·H + (x div W)·W·H + (y mod H)·W + (x mod W).
- R3: In tiled mode with S a multiple of W, the W·H samples of any one tile map onto W·H distinct, consecutive addresses.
- R4: Mode values 2 and 3 are illegal. A valid request with either value gives out_err = 1 and out_addr = 0. Modes 0 and 1 give out_err = 0. out_err is never high while out_valid is low.
- R5: out_valid equals in_valid delayed by exactly two clock cycles, and the result belongs to the request accepted two cycles earlier. Requests may arrive on consecutive cycles.
- R6: While rst_n is low, out_valid, out_err and out_addr are all zero.
- R7: Tiled results are taken modulo 2^ADDR_W. This covers a stride exponent at or above ADDR_W, where the row is 0 and the column is the whole offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request present this cycle |
| in_mode | input | 2 | 0 linear, 1 tiled, 2 and 3 illegal |
| in_offset | input | ADDR_W | Linear sample offset in the plane |
| in_stride_log2 | input | SH_W | Base-2 exponent of the plane stride |
| out_valid | output | 1 | Result present this cycle |
| out_addr | output | ADDR_W | Remapped address |
| out_err | output | 1 | Request carried an illegal mode |

## Verification
The bench targets four kinds of mistake.

- Stride exponents below the tile width exponent leave the tile-column term at zero. A design that assumed a stride of at least one tile would corrupt those addresses.
- Exponents at or above the address width push every row into row 0. A design with a broken shift or mask would smear column bits into the row and produce wrong addresses.
- A whole tile is swept with a fixed stride. A transposed or badly scaled term would leave gaps or overlaps, which show up as a wrong address sum or range.
- Back-to-back requests with idle gaps and mixed illegal modes are run through the pipeline. These expose a misaligned valid bit or an error flag that leaks into neighbouring results.

// File: rtl/tile_pkg.sv
package tile_pkg;
  typedef enum logic [1:0] {
    MODE_LINEAR = 2'd0,
    MODE_TILED  = 2'd1,
    MODE_RSVD2  = 2'd2,
    MODE_RSVD3  = 2'd3
  } tile_mode_e;

  typedef enum logic [1:0] {
    KIND_PASS  = 2'd0,
    KIND_TILE  = 2'd1,
    KIND_ERROR = 2'd2
  } tile_kind_e;
endpackage

// File: rtl/tile_split.sv
module tile_split
  import tile_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int SH_W   = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [1:0]        in_mode,
  input  logic [ADDR_W-1:0] in_offset,
  input  logic [SH_W-1:0]   in_stride_log2,
  output logic              s1_valid,
  output tile_kind_e        s1_kind,
  output logic [ADDR_W-1:0] s1_offset,
  output logic [ADDR_W-1:0] s1_col,
  output logic [ADDR_W-1:0] s1_row,
  output logic [SH_W-1:0]   s1_sh
);
  function automatic logic [ADDR_W-1:0] col_of(logic [ADDR_W-1:0] off,
                                               logic [SH_W-1:0] sh);
    logic [ADDR_W-1:0] keep;
    keep = ~({ADDR_W{1'b1}} << sh);
    return off & keep;
  endfunction

  function automatic logic [ADDR_W-1:0] row_of(logic [ADDR_W-1:0] off,
                                               logic [SH_W-1:0] sh);
    return off >> sh;
  endfunction

  function automatic tile_kind_e kind_of(logic [1:0] m);
    case (tile_mode_e'(m))
      MODE_LINEAR: return KIND_PASS;
      MODE_TILED:  return KIND_TILE;
      default:     return KIND_ERROR;
    endcase
  endfunction

  tile_kind_e        kind_d;
  logic [ADDR_W-1:0] col_d;
  logic [ADDR_W-1:0] row_d;

  always_comb begin
    kind_d = kind_of(in_mode);
    col_d  = col_of(in_offset, in_stride_log2);
    row_d  = row_of(in_offset, in_stride_log2);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid  <= 1'b0;
      s1_kind   <= KIND_PASS;
      s1_offset <= '0;
      s1_col    <= '0;
      s1_row    <= '0;
      s1_sh     <= '0;
    end else begin
      s1_valid <= in_valid;
      if (in_valid) begin
        s1_kind   <= kind_d;
        s1_offset <= in_offset;
        s1_col    <= col_d;
        s1_row    <= row_d;
        s1_sh     <= in_stride_log2;
      end
    end
  end

  // R5
  split_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> s1_valid);
  // R5
  split_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !s1_valid);
endmodule

// File: rtl/tile_merge.sv
module tile_merge
  import tile_pkg::*;
#(
  parameter int ADDR_W     = 24,
  parameter int SH_W       = 5,
  parameter int BLK_W_LOG2 = 5,
  parameter int BLK_H_LOG2 = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s1_valid,
  input  tile_kind_e        s1_kind,
  input  logic [ADDR_W-1:0] s1_offset,
  input  logic [ADDR_W-1:0] s1_col,
  input  logic [ADDR_W-1:0] s1_row,
  input  logic [SH_W-1:0]   s1_sh,
  output logic              out_valid,
  output logic [ADDR_W-1:0] out_addr,
  output logic              out_err
);
  localparam int TILE_LOG2 = BLK_W_LOG2 + BLK_H_LOG2;
  localparam logic [ADDR_W-1:0] W_MASK = ADDR_W'((1 << BLK_W_LOG2) - 1);
  localparam logic [ADDR_W-1:0] H_MASK = ADDR_W'((1 << BLK_H_LOG2) - 1);

  function automatic logic [ADDR_W-1:0] assemble(logic [ADDR_W-1:0] col,
                                                 logic [ADDR_W-1:0] row,
                                                 logic [SH_W-1:0] sh);
    logic [ADDR_W-1:0] band_term, tile_term, line_term, pix_term;
    band_term = (row >> BLK_H_LOG2) << (BLK_H_LOG2 + int'(sh));
    tile_term = (col >> BLK_W_LOG2) << TILE_LOG2;
    line_term = (row & H_MASK) << BLK_W_LOG2;
    pix_term  = col & W_MASK;
    return band_term + tile_term + line_term + pix_term;
  endfunction

  logic [ADDR_W-1:0] addr_d;
  logic              err_d;

  always_comb begin
    err_d = 1'b0;
    case (s1_kind)
      KIND_PASS: addr_d = s1_offset;
      KIND_TILE: addr_d = assemble(s1_col, s1_row, s1_sh);
      default: begin
        addr_d = '0;
        err_d  = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_addr  <= '0;
      out_err   <= 1'b0;
    end else begin
      out_valid <= s1_valid;
      out_addr  <= s1_valid ? addr_d : '0;
      out_err   <= s1_valid & err_d;
    end
  end

  // R1
  linear_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && s1_kind == KIND_PASS) |=> (out_addr == $past(s1_offset)));
  // R4
  err_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_err |-> (out_addr == '0));
  // R4
  err_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_err |-> out_valid);
  // R5
  merge_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s1_valid |=> out_valid);
endmodule

// File: rtl/tile_addr_remap.sv
module tile_addr_remap
  import tile_pkg::*;
#(
  parameter int ADDR_W     = 24,
  parameter int BLK_W_LOG2 = 5,
  parameter int BLK_H_LOG2 = 4,
  parameter int SH_W       = $clog2(ADDR_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [1:0]        in_mode,
  input  logic [ADDR_W-1:0] in_offset,
  input  logic [SH_W-1:0]   in_stride_log2,
  output logic              out_valid,
  output logic [ADDR_W-1:0] out_addr,
  output logic              out_err
);
  logic              s1_valid;
  tile_kind_e        s1_kind;
  logic [ADDR_W-1:0] s1_offset;
  logic [ADDR_W-1:0] s1_col;
  logic [ADDR_W-1:0] s1_row;
  logic [SH_W-1:0]   s1_sh;

  tile_split #(.ADDR_W(ADDR_W), .SH_W(SH_W)) u_split (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_mode(in_mode),
    .in_offset(in_offset), .in_stride_log2(in_stride_log2),
    .s1_valid(s1_valid), .s1_kind(s1_kind), .s1_offset(s1_offset),
    .s1_col(s1_col), .s1_row(s1_row), .s1_sh(s1_sh)
  );

  tile_merge #(.ADDR_W(ADDR_W), .SH_W(SH_W),
               .BLK_W_LOG2(BLK_W_LOG2), .BLK_H_LOG2(BLK_H_LOG2)) u_merge (
    .clk(clk), .rst_n(rst_n),
    .s1_valid(s1_valid), .s1_kind(s1_kind), .s1_offset(s1_offset),
    .s1_col(s1_col), .s1_row(s1_row), .s1_sh(s1_sh),
    .out_valid(out_valid), .out_addr(out_addr), .out_err(out_err)
  );

  // R6
  always_comb begin
    if (!rst_n) begin
      reset_quiet_chk: assert (!s1_valid && !out_valid && !out_err);
    end
  end
endmodule

// File: tb/tile_addr_remap_bench.sv
module tile_addr_remap_bench;
  localparam int AW = 24;
  localparam int SHW = 5;
  localparam int WL = 5;
  localparam int HL = 4;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           in_valid = 1'b0;
  logic [1:0]     in_mode = 2'd0;
  logic [AW-1:0]  in_offset = '0;
  logic [SHW-1:0] in_stride_log2 = '0;
  logic           out_valid;
  logic [AW-1:0]  out_addr;
  logic           out_err;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  bit      hv [2];
  longint  ha [2];
  bit      he [2];
  bit      h3 [2];
  string   ht [2];

  longint r3_sum = 0;
  longint r3_min = 64'h7fffffff;
  longint r3_max = 0;
  int     r3_cnt = 0;

  always #4 clk = ~clk;

  tile_addr_remap u_tile_addr_remap (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_mode(in_mode),
    .in_offset(in_offset), .in_stride_log2(in_stride_log2),
    .out_valid(out_valid), .out_addr(out_addr), .out_err(out_err)
  );

  function automatic longint ref_addr(int mode, longint off, int sh);
    longint s, x, y, w, h, r;
    if (mode == 0) return off;
    if (mode > 1) return 0;
    w = 64'd1 << WL;
    h = 64'd1 << HL;
    s = 64'd1 << sh;
    x = off % s;
    y = off / s;
    r = s * (y / h) * h + (x / w) * w * h + (y % h) * w + (x % w);
    return r & ((64'd1 << AW) - 1);
  endfunction

  task automatic check(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(bit v, int mode, longint off, int sh, string tag, bit r3);
    @(negedge clk);
    check({tag, " R5 valid"}, out_valid, hv[1]);
    if (hv[1]) begin
      check({tag, " R4 err"}, out_err, he[1]);
      check(ht[1], out_addr, ha[1]);
      if (h3[1]) begin
        r3_sum += out_addr;
        r3_cnt++;
        if (out_addr < r3_min) r3_min = out_addr;
        if (out_addr > r3_max) r3_max = out_addr;
      end
    end else begin
      check({tag, " R4 idle err"}, out_err, 0);
    end
    hv[1] = hv[0]; ha[1] = ha[0]; he[1] = he[0]; h3[1] = h3[0]; ht[1] = ht[0];
    hv[0] = v;
    ha[0] = ref_addr(mode, off, sh);
    he[0] = v && mode > 1;
    h3[0] = v && r3;
    ht[0] = tag;
    in_valid = v;
    in_mode = 2'(mode);
    in_offset = AW'(off);
    in_stride_log2 = SHW'(sh);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed1234));
    for (int i = 0; i < 2; i++) begin hv[i] = 0; ha[i] = 0; he[i] = 0; h3[i] = 0; ht[i] = "idle"; end
    repeat (3) @(negedge clk);
    check("R6 reset valid", out_valid, 0);
    check("R6 reset err", out_err, 0);
    check("R6 reset addr", out_addr, 0);
    rst_n = 1'b1;

    step(1, 0, 24'h123456, 7, "R1 linear", 0);
    step(1, 1, 24'h000000, 8, "R2 origin", 0);
    step(1, 1, 24'h000121, 8, "R2 row1", 0);
    step(1, 2, 24'habcdef, 8, "R4 mode2", 0);
    step(0, 1, 24'h000055, 8, "R5 gap", 0);
    step(1, 3, 24'h00ffff, 3, "R4 mode3", 0);
    step(1, 1, 24'h0003ff, 2, "R2 narrow stride", 0);
    step(1, 1, 24'hfedcba, 24, "R7 stride at width", 0);
    step(1, 1, 24'hffffff, 31, "R7 stride over width", 0);
    step(1, 1, 24'hffffff, 10, "R7 top offset", 0);
    step(1, 1, 24'h00abcd, 0, "R2 unit stride", 0);

    for (int yy = 16; yy < 32; yy++)
      for (int xx = 64; xx < 96; xx++)
        step(1, 1, longint'(yy) * 128 + xx, 7, "R3 tile sweep", 1);

    for (int i = 0; i < 3000; i++) begin
      int m, r, s;
      r = $urandom % 8;
      m = (r < 3) ? 0 : (r < 7) ? 1 : 2 + ($urandom % 2);
      s = $urandom % 27;
      step(($urandom % 4) != 0, m, longint'($urandom % (1 << AW)), s, "R2 random", 0);
    end
    step(0, 0, 0, 0, "R5 drain", 0);
    step(0, 0, 0, 0, "R5 drain", 0);
    step(0, 0, 0, 0, "R5 drain", 0);

    check("R3 tile count", r3_cnt, 512);
    check("R3 tile min", r3_min, 3072);
    check("R3 tile max", r3_max, 3583);
    check("R3 tile sum", r3_sum, 1703680);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule